// File: doc/BRIEF.md
# Free-Running Time Base with Split Byte Reads

This block is a 16-bit up-counter that serves as the common time reference for a group of capture/compare channels. A single enable input moves it between two states. In standby the count sits at zero and nothing is updated. When the enable is set, the counter runs from zero and advances once per tick. A tick comes every N system clocks, and N is set by a divisor input. The full count goes to the channels on every clock. When the count wraps from all-ones to zero, a one-cycle event pulse is sent to the interrupt logic and to the channels.

Software reads the count through an 8-bit read port, one byte per access, low byte first. A low-byte read also copies the high byte into a shadow register. The next high-byte read returns that stored copy, so the two halves always come from the same instant, even when the counter has carried into the high byte between the two reads. A high-byte read that has no pending low-byte read returns the live high byte.

Top module: `tbase_timer`

## Requirements
- R1: After a synchronous active-low reset, `count_o` is 0, `wrap_evt` is 0, and a low-byte read returns 0.
- R2: While `run_en` is 0, `count_o` is held at 0 and `wrap_evt` stays 0, whatever the read and divisor inputs do.
- R3: While `run_en` is 1 with `div_sel` = d, `count_o` rises by exactly 1 every d+1 clocks. The first step comes at the clock edge that ends the (d+1)-th enabled cycle.
- R4: When the count steps from FFFFh, it becomes 0000h, and `wrap_evt` is 1 for exactly the one cycle in which `count_o` first shows that 0000h.
- R5: A read with `rd_en`=1 and `rd_hi`=0 (`rd_hi`=0 selects the low byte) returns `count_o[7:0]` on `rd_data` in the same cycle. It also stores `count_o[15:8]` as a pending shadow byte.
- R6: A read with `rd_en`=1 and `rd_hi`=1, made while a shadow byte is pending, returns the shadow byte even if the counter has moved on since. The pending shadow is then consumed.
- R7: A high-byte read with no pending shadow byte returns the live `count_o[15:8]`.
- R8: Going to standby discards a pending shadow byte. A high-byte read after the counter is re-enabled returns the live high byte.
- R9: `count_o` shows the current count on every cycle, with no read needed.
- R10: Setting `div_sel` lower while running takes effect at once. If the prescale phase already reached the new divisor, the next step happens at the very next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | 1 = active (counting), 0 = standby |
| div_sel | input | 8 | Tick divisor minus one; one tick every div_sel+1 clocks |
| rd_en | input | 1 | Byte read strobe |
| rd_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| rd_data | output | 8 | Read data, valid in the cycle of the strobe |
| count_o | output | 16 | Live count to the channels |
| wrap_evt | output | 1 | One-cycle pulse on the wrap to zero |

## Verification
A wrong prescale phase shows on `count_o` at the next expected step, because the count then moves one clock early or late. A stale or missing shadow flag shows only on the high-byte read after it. For this reason the bench makes low/high read pairs that straddle a carry into the high byte, and reads the high byte after a trip through standby. A wrong wrap detection shows on `wrap_evt` in the cycle the count returns to zero, which the bench reaches by counting through the full range.

// File: rtl/tbase_pkg.sv
// Shared types for the free-running time base.
// Assumes nothing beyond a plain synthesizable flow.
package tbase_pkg;

    // Byte select on the read port; the encoding is fixed by the rd_hi pin.
    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

endpackage

// File: rtl/tbase_prescale.sv
// Tick generator: one tick every div_sel+1 clocks while running.
// Assumes the phase restarts from zero whenever the block leaves standby.
// The >= compare lets a lowered divisor act at once.
module tbase_prescale #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    logic [DIV_W-1:0] phase;

    // Tick when the phase has reached the divisor.
    always_comb begin
        tick = run_en && (phase >= div_sel);
    end

    // Phase counter, held at zero in standby.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            phase <= '0;
        end else if (tick) begin
            phase <= '0;
        end else begin
            phase <= phase + DIV_W'(1);
        end
    end

endmodule

// File: rtl/tbase_count.sv
// Up-counter with a registered wrap pulse.
// Assumes tick is only high while run_en is high.
// wrap_evt is high in the cycle the count first shows zero after a wrap.
module tbase_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt
);

    // Count and wrap pulse; standby clears both.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            count    <= '0;
            wrap_evt <= 1'b0;
        end else begin
            wrap_evt <= tick && (count == '1);
            if (tick) begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tbase_rdport.sv
// Byte read port with a high-byte shadow.
// A low-byte read captures the high part. The next high-byte read
// returns that capture and consumes it. Standby drops the capture.
// Assumes CNT_W - BYTE_W <= BYTE_W, so the high part fits one byte.
module tbase_rdport
    import tbase_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [CNT_W-1:0]  count,
    input  logic              rd_en,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int HI_W = CNT_W - BYTE_W;

    byte_sel_e       sel;
    logic [HI_W-1:0] shadow;
    logic            shadow_vld;
    logic [HI_W-1:0] hi_val;

    assign sel = byte_sel_e'(rd_hi);

    // Shadow capture on low reads, release on high reads.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            shadow     <= '0;
            shadow_vld <= 1'b0;
        end else if (rd_en) begin
            if (sel == SEL_LO) begin
                shadow     <= count[CNT_W-1:BYTE_W];
                shadow_vld <= 1'b1;
            end else begin
                shadow_vld <= 1'b0;
            end
        end
    end

    // Select the high source, then the byte to return.
    always_comb begin
        hi_val  = shadow_vld ? shadow : count[CNT_W-1:BYTE_W];
        rd_data = (sel == SEL_HI) ? BYTE_W'(hi_val) : count[BYTE_W-1:0];
    end

endmodule

// File: rtl/tbase_timer.sv
// Free-running time base top: prescaler, counter and byte read port.
// Assumes run_en comes from an enable bit in the same clock domain.
module tbase_timer #(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              rd_en,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              wrap_evt
);

    logic tick;

    tbase_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .div_sel (div_sel),
        .tick    (tick)
    );

    tbase_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tick     (tick),
        .count    (count_o),
        .wrap_evt (wrap_evt)
    );

    tbase_rdport #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .count   (count_o),
        .rd_en   (rd_en),
        .rd_hi   (rd_hi),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/tbase_timer_chk.sv
// Port-level properties of the time base, attached by bind.
module tbase_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              rd_en,
    input logic              rd_hi,
    input logic [BYTE_W-1:0] rd_data,
    input logic [CNT_W-1:0]  count_o,
    input logic              wrap_evt
);

    localparam int HI_W = CNT_W - BYTE_W;

    p_standby_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (count_o == '0) && !wrap_evt);

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && (count_o != $past(count_o)))
            |-> count_o == CNT_W'($past(count_o) + CNT_W'(1)));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |-> (count_o == '0) && ($past(count_o) == '1));

    p_wrap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> !wrap_evt);

    p_shadow_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hi && run_en) |=>
            ((rd_en && rd_hi && run_en)
                |-> rd_data[HI_W-1:0] == $past(count_o[CNT_W-1:BYTE_W])));

endmodule

bind tbase_timer tbase_timer_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .rd_en    (rd_en),
    .rd_hi    (rd_hi),
    .rd_data  (rd_data),
    .count_o  (count_o),
    .wrap_evt (wrap_evt)
);

// File: tb/tbase_timer_tb.sv
`timescale 1ns/1ps
module tbase_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [7:0] div_sel = 8'd0;
    logic       rd_en = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] rd_data;
    logic [15:0] count_o;
    logic       wrap_evt;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    int m_cnt = 0;
    int m_phase = 0;
    int m_sh = 0;
    bit m_sv = 0;
    bit m_wrap = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    tbase_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .div_sel  (div_sel),
        .rd_en    (rd_en),
        .rd_hi    (rd_hi),
        .rd_data  (rd_data),
        .count_o  (count_o),
        .wrap_evt (wrap_evt)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs, compare against the model, advance one clock.
    task automatic step(bit run, int dv, bit rd, bit hi);
        int exp_rd;
        string rtag;
        bit tk;
        run_en = run; div_sel = 8'(dv); rd_en = rd; rd_hi = hi;
        #1;
        chk({cur_tag, " R9 count"}, int'(count_o), m_cnt);
        chk("R4 wrap_evt", int'(wrap_evt), int'(m_wrap));
        if (rd) begin
            if (!hi) begin exp_rd = m_cnt & 255; rtag = "R5 low read"; end
            else if (m_sv) begin exp_rd = m_sh; rtag = "R6 shadow read"; end
            else begin exp_rd = m_cnt >> 8; rtag = "R7 live high read"; end
            if (cur_tag == "R8" && hi) rtag = "R8 high read after standby";
            chk(rtag, int'(rd_data), exp_rd);
        end
        @(posedge clk);
        if (!run) begin
            m_cnt = 0; m_phase = 0; m_wrap = 0; m_sv = 0; m_sh = 0;
        end else begin
            if (rd && !hi) begin m_sh = m_cnt >> 8; m_sv = 1; end
            else if (rd && hi) m_sv = 0;
            tk = (m_phase >= dv);
            m_phase = tk ? 0 : m_phase + 1;
            m_wrap = tk && (m_cnt == 65535);
            if (tk) m_cnt = (m_cnt + 1) % 65536;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk("R1 count", int'(count_o), 0);
        chk("R1 wrap_evt", int'(wrap_evt), 0);
        chk("R1 low read", int'(rd_data), 0);

        // R2: standby ignores reads and divisor
        cur_tag = "R2";
        for (int i = 0; i < 10; i++) step(0, i, i[0], i[1]);

        // R3: divisor 0, count every clock
        cur_tag = "R3";
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0);

        // R6: pair straddling a carry into the high byte
        cur_tag = "R6";
        while ((m_cnt & 255) != 8'hFE) step(1, 0, 0, 0);
        step(1, 0, 1, 0);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        step(1, 0, 1, 1);

        // R7: high reads with no pending low read
        cur_tag = "R7";
        step(1, 0, 1, 1);
        step(1, 0, 0, 0);
        step(1, 0, 1, 1);

        // R3: slower divisor
        cur_tag = "R3";
        for (int i = 0; i < 40; i++) step(1, 3, 0, 0);

        // R10: lower the divisor once the phase is past the new value
        cur_tag = "R10";
        while (m_phase != 4) step(1, 5, 0, 0);
        for (int i = 0; i < 12; i++) step(1, 2, 0, 0);

        // R8: standby drops a pending shadow
        cur_tag = "R8";
        for (int i = 0; i < 300; i++) step(1, 0, 0, 0);
        step(1, 0, 1, 0);
        step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 1, 1);

        // R4: run through the full range and the wrap
        cur_tag = "R4";
        while (m_cnt != 16'hFFFF) step(1, 0, 0, 0);
        step(1, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
        cur_tag = "R6";
        step(1, 0, 1, 1);
        cur_tag = "R4";
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0);

        // R2: back to standby
        cur_tag = "R2";
        for (int i = 0; i < 5; i++) step(0, 0, 1, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule